// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

A single counter/timer with a programmable prescaler, four match registers, three match outputs and one capture channel. The prescaler counts up to a programmed limit. Each time it wraps, the main counter takes one step. The prescaler is fed either by every clock (timer mode) or by synchronized rising edges of an external count input (counter mode).

Each match register compares against the counter when the counter is about to step. On a hit, the register can set an interrupt flag, send the counter back to zero, or stop the counter. Each match output can be driven low, driven high, toggled or held on its own match. It can instead run as a single-edge PWM output whose period comes from a match register that resets the counter. A capture channel stores the counter value on a selected edge of a synchronized capture input. Software configures and reads the block through a simple register port: writes take effect at the clock edge and reads are combinational.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, the counter is disabled, all match outputs are low and the interrupt output is low.
- R2: Control (address 0) has bit 0 = run, bit 1 = hold-reset and bit 2 = counter mode. The prescaler limit is at address 1 and the prescaler value reads at address 2. While running in timer mode, the prescaler rises by one each clock. On the clock it equals the limit, it returns to 0 and the counter (address 3) advances by one in that same clock. The counter therefore advances once every limit+1 clocks.
- R3: In counter mode, the prescaler advances only on a rising edge of the count input, seen after a two-flop synchronizer. At all other times the prescaler and counter hold.
- R4: Match values are at addresses 4 to 7. Address 8 holds three bits per match i: bit 3i = flag, bit 3i+1 = reset, bit 3i+2 = stop. A match happens when the counter is about to advance and equals the match value. With reset selected, the counter goes to 0 instead of advancing. With no action selected, counting continues.
- R5: A stop match holds the counter at the match value and clears the run bit. The stop wins over a control write in the same clock.
- R6: Address 11, bits 2i+1:2i, select the action of output i on match i: 0 hold, 1 drive low, 2 drive high, 3 toggle.
- R7: Address 11, bit 8+i, puts output i in PWM mode. The output is then high while the counter is at or above match i and low below it, so a match value of 0 gives a constant high.
- R8: Address 9 holds the capture controls: bit 0 enables rising edges, bit 1 enables falling edges, bit 2 enables the flag. An enabled edge of the capture input, taken after a two-flop synchronizer, copies the counter into address 10. If a reset match happens in the same clock, the value stored is the one from before the reset.
- R9: Address 12 holds sticky flags: bits 3:0 for matches, bit 4 for capture. Writing 1 to a bit clears it, and a new event in the same clock wins over the clear. The interrupt output is high while any flag is set.
- R10: While hold-reset is set, the counter and prescaler are held at 0 and no match occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | W | Read data (combinational) |
| cnt_in | input | 1 | External count input |
| cap_in | input | 1 | Capture input |
| mat_out | output | 3 | Match / PWM outputs |
| irq | output | 1 | Interrupt, OR of the flags |

## Verification
The assertions watch, on every cycle, that the counter moves only on a prescaler wrap and only by one or back to zero. They also check that only a reset match, hold-reset or a wrap can send it to zero, that a stop match clears run, that hold-reset zeroes both counters and that flags drop only under a clear write. The bench's scenarios cover what the assertions cannot see: the exact step rate for a given limit, edge counting through the synchronizer, each output action code, PWM duty and the constant-high zero case, captured values on rising and falling edges and at a reset collision, and the order of flag set against flag clear.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [3:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         cnt_in,
  input  logic         cap_in,
  output logic [2:0]   mat_out,
  output logic         irq
);
  localparam int NM = 4;
  localparam int NO = 3;

  logic [2:0]    ctl;
  logic [W-1:0]  plim, pc, tc, capv;
  logic [W-1:0]  mr [NM];
  logic [3*NM-1:0] mctl;
  logic [2:0]    capc;
  logic [2*NO-1:0] act;
  logic [NO-1:0] pwm, ost;
  logic [NM:0]   flags, fset;
  logic [2:0]    cs, ns;
  logic [NM-1:0] hit;
  logic          run, swr, tick, step, wrap, inc, rst_hit, stop_hit, cap_ev;

  assign run  = ctl[0];
  assign swr  = ctl[1];
  assign tick = ctl[2] ? (ns[1] & ~ns[2]) : 1'b1;
  assign step = run & ~swr & tick;
  assign wrap = (pc == plim);
  assign inc  = step & wrap;
  assign cap_ev = (capc[0] & cs[1] & ~cs[2]) | (capc[1] & ~cs[1] & cs[2]);

  always_comb begin
    rst_hit  = 1'b0;
    stop_hit = 1'b0;
    for (int i = 0; i < NM; i++) begin
      hit[i]   = inc && (tc == mr[i]);
      fset[i]  = hit[i] & mctl[3*i];
      rst_hit  = rst_hit  | (hit[i] & mctl[3*i+1]);
      stop_hit = stop_hit | (hit[i] & mctl[3*i+2]);
    end
    fset[NM] = cap_ev & capc[2];
  end

  function automatic logic wsel(input logic [3:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; plim <= '0; pc <= '0; tc <= '0; capv <= '0;
      for (int i = 0; i < NM; i++) mr[i] <= '0;
      mctl <= '0; capc <= '0; act <= '0; pwm <= '0; ost <= '0;
      flags <= '0; cs <= '0; ns <= '0;
    end else begin
      cs <= {cs[1:0], cap_in};
      ns <= {ns[1:0], cnt_in};

      if (swr)       pc <= '0;
      else if (step) pc <= wrap ? '0 : pc + 1'b1;

      if (swr)                       tc <= '0;
      else if (inc && rst_hit)       tc <= '0;
      else if (inc && !stop_hit)     tc <= tc + 1'b1;

      if (cap_ev) capv <= tc;

      if (wsel(4'd0)) ctl <= wr_data[2:0];
      if (stop_hit)   ctl[0] <= 1'b0;
      if (wsel(4'd1)) plim <= wr_data;
      for (int i = 0; i < NM; i++)
        if (wsel(4'(4 + i))) mr[i] <= wr_data;
      if (wsel(4'd8)) mctl <= wr_data[3*NM-1:0];
      if (wsel(4'd9)) capc <= wr_data[2:0];
      if (wsel(4'd11)) begin
        act <= wr_data[2*NO-1:0];
        pwm <= wr_data[8+NO-1:8];
      end

      flags <= (flags & ~(wsel(4'd12) ? wr_data[NM:0] : '0)) | fset;

      for (int i = 0; i < NO; i++)
        if (hit[i])
          case (act[2*i +: 2])
            2'd1: ost[i] <= 1'b0;
            2'd2: ost[i] <= 1'b1;
            2'd3: ost[i] <= ~ost[i];
            default: ;
          endcase
    end
  end

  for (genvar g = 0; g < NO; g++) begin : g_out
    assign mat_out[g] = pwm[g] ? (tc >= mr[g]) : ost[g];
  end

  assign irq = |flags;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      4'd0:  rd_data[2:0] = ctl;
      4'd1:  rd_data = plim;
      4'd2:  rd_data = pc;
      4'd3:  rd_data = tc;
      4'd4, 4'd5, 4'd6, 4'd7: rd_data = mr[rd_addr[1:0]];
      4'd8:  rd_data[3*NM-1:0] = mctl;
      4'd9:  rd_data[2:0] = capc;
      4'd10: rd_data = capv;
      4'd11: begin
        rd_data[2*NO-1:0] = act;
        rd_data[8+NO-1:8] = pwm;
      end
      4'd12: rd_data[NM:0] = flags;
      default: rd_data = '0;
    endcase
  end
endmodule

module match_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [3:0]   wr_addr,
  input logic [W-1:0] tc,
  input logic [W-1:0] pc,
  input logic [W-1:0] plim,
  input logic         swr,
  input logic         run,
  input logic [4:0]   flags,
  input logic         rst_hit,
  input logic         stop_hit
);
  a_r2_step_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tc != $past(tc)) |-> (($past(pc) == $past(plim)) || $past(swr)));

  a_r2_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (tc != $past(tc)) |-> ((tc == $past(tc) + 1'b1) || (tc == '0)));

  a_r4_zero_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc == '0) && ($past(tc) != '0)) |-> ($past(rst_hit) || $past(swr) || ($past(tc) == '1)));

  a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !run);

  a_r5_run_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(stop_hit) || $past(wr_en && (wr_addr == 4'd0))));

  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> $past(wr_en && (wr_addr == 4'd12)));

  a_r10_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> ((tc == '0) && (pc == '0)));
endmodule

bind match_timer match_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .tc(tc), .pc(pc), .plim(plim), .swr(swr), .run(run),
  .flags(flags), .rst_hit(rst_hit), .stop_hit(stop_hit)
);

// File: tb/test_match_timer.sv
`timescale 1ns/100ps
module test_match_timer;
  localparam int W = 16;
  localparam int MASK = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = 4'd3;
  logic [W-1:0] wr_data = '0, rd_data;
  logic cnt_in = 1'b0, cap_in = 1'b0;
  logic [2:0] mat_out;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  match_timer #(.W(W)) i_match_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_in(cnt_in), .cap_in(cap_in),
    .mat_out(mat_out), .irq(irq)
  );

  // behavioural reference state
  int m_run, m_swr, m_mode, m_plim, m_pc, m_tc, m_capv, m_mctl, m_capc, m_act, m_pwm, m_flags;
  int m_mr[4];
  int m_ost[3];
  int c0, c1, c2, n0, n1, n2;
  int t_tick, t_step, t_inc, t_rh, t_sh, t_ce, t_set, t_clr;
  int t_hit[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_swr = 0; m_mode = 0; m_plim = 0; m_pc = 0; m_tc = 0; m_capv = 0;
      m_mctl = 0; m_capc = 0; m_act = 0; m_pwm = 0; m_flags = 0;
      foreach (m_mr[i]) m_mr[i] = 0;
      foreach (m_ost[i]) m_ost[i] = 0;
      c0 = 0; c1 = 0; c2 = 0; n0 = 0; n1 = 0; n2 = 0;
    end else begin
      t_tick = m_mode ? (n1 && !n2) : 1;
      t_step = m_run && !m_swr && t_tick;
      t_inc  = t_step && (m_pc == m_plim);
      t_rh = 0; t_sh = 0; t_set = 0;
      for (int i = 0; i < 4; i++) begin
        t_hit[i] = t_inc && (m_tc == m_mr[i]);
        if (t_hit[i] && ((m_mctl >> (3*i)) & 1))   t_set |= (1 << i);
        if (t_hit[i] && ((m_mctl >> (3*i+1)) & 1)) t_rh = 1;
        if (t_hit[i] && ((m_mctl >> (3*i+2)) & 1)) t_sh = 1;
      end
      t_ce = ((m_capc & 1) && c1 && !c2) || (((m_capc >> 1) & 1) && !c1 && c2);
      if (t_ce) begin
        m_capv = m_tc;
        if ((m_capc >> 2) & 1) t_set |= 16;
      end
      for (int i = 0; i < 3; i++)
        if (t_hit[i])
          case ((m_act >> (2*i)) & 3)
            1: m_ost[i] = 0;
            2: m_ost[i] = 1;
            3: m_ost[i] = 1 - m_ost[i];
            default: ;
          endcase
      if (m_swr) begin m_pc = 0; m_tc = 0; end
      else begin
        if (t_step) m_pc = (m_pc == m_plim) ? 0 : ((m_pc + 1) & MASK);
        if (t_inc) begin
          if (t_rh) m_tc = 0;
          else if (!t_sh) m_tc = (m_tc + 1) & MASK;
        end
      end
      t_clr = (wr_en && wr_addr == 12) ? int'(wr_data) : 0;
      m_flags = (m_flags & ~t_clr & 31) | t_set;
      if (wr_en) case (wr_addr)
        0: begin m_run = wr_data[0]; m_swr = wr_data[1]; m_mode = wr_data[2]; end
        1: m_plim = wr_data;
        4, 5, 6, 7: m_mr[wr_addr - 4] = wr_data;
        8: m_mctl = wr_data & 12'hFFF;
        9: m_capc = wr_data & 7;
        11: begin m_act = wr_data & 63; m_pwm = (wr_data >> 8) & 7; end
        default: ;
      endcase
      if (t_sh) m_run = 0;
      c2 = c1; c1 = c0; c0 = cap_in;
      n2 = n1; n1 = n0; n0 = cnt_in;
    end
  end

  function automatic int m_out();
    int o = 0;
    for (int i = 0; i < 3; i++)
      if ((m_pwm >> i) & 1) o |= (m_tc >= m_mr[i]) << i;
      else o |= m_ost[i] << i;
    return o;
  endfunction

  function automatic int m_read(input int a);
    case (a)
      0: return m_run | (m_swr << 1) | (m_mode << 2);
      1: return m_plim;
      2: return m_pc;
      3: return m_tc;
      4, 5, 6, 7: return m_mr[a-4];
      8: return m_mctl;
      9: return m_capc;
      10: return m_capv;
      11: return m_act | (m_pwm << 8);
      12: return m_flags;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison (counter through the read port, outputs, interrupt)
  always @(negedge clk) begin
    if (rst_n && !done && rd_addr == 4'd3) begin
      check("R2 count", int'(rd_data), m_tc);
      check("R6/R7 mat_out", int'(mat_out), m_out());
      check("R9 irq", int'(irq), (m_flags != 0) ? 1 : 0);
    end
  end

  task automatic wreg(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = W'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rdchk(input string req, input int a);
    rd_addr = 4'(a);
    #1;
    check(req, int'(rd_data), m_read(a));
    rd_addr = 4'd3;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    for (int a = 0; a <= 12; a++) rdchk("R1 reset reg", a);
    check("R1 reset mat_out", int'(mat_out), 0);
    check("R1 reset irq", int'(irq), 0);

    // R2/R4/R6: prescale by 3, match0 flags and resets at 4, out0 toggles
    wreg(1, 2); wreg(4, 4); wreg(8, 12'h003); wreg(11, 6'h03); wreg(0, 1);
    idle(5); rdchk("R2 prescaler", 2);
    idle(60); rdchk("R4 flags", 12); rdchk("R4 count", 3);

    // R9: write-1 clear
    wreg(12, 1); rdchk("R9 cleared", 12);
    idle(20); rdchk("R9 re-set", 12);

    // R8: rising capture with flag, then falling, then collisions with reset
    wreg(9, 3'b101);
    cap_in = 1; idle(3); cap_in = 0; idle(4);
    rdchk("R8 rise capture", 10); rdchk("R8 flag", 12);
    wreg(9, 3'b010);
    cap_in = 1; idle(5); cap_in = 0; idle(5);
    rdchk("R8 fall capture", 10);
    wreg(1, 0); wreg(9, 3'b011);
    for (int k = 0; k < 30; k++) begin
      cap_in = ~cap_in; idle(1 + (k % 5));
      rdchk("R8 capture vs reset", 10);
    end
    wreg(12, 31); rdchk("R9 clear all", 12);

    // R10: hold-reset
    wreg(0, 3); idle(4); rdchk("R10 count", 3); rdchk("R10 prescaler", 2);
    // R5: stop at match1 = 7
    wreg(8, 12'h020); wreg(5, 7); wreg(0, 1);
    idle(25); rdchk("R5 run cleared", 0); rdchk("R5 held", 3);

    // R6: low, high, toggle actions; match3 resets at 9
    wreg(0, 2); wreg(4, 3); wreg(5, 5); wreg(6, 6); wreg(7, 9);
    wreg(8, 12'h400); wreg(11, 6'h39); wreg(1, 1); wreg(0, 1);
    idle(80); rdchk("R6 actions", 11);

    // R7: PWM on all three outputs, period from match3 = 6
    wreg(4, 0); wreg(5, 3); wreg(6, 9); wreg(7, 6); wreg(1, 0);
    wreg(11, 12'h700);
    idle(40);
    check("R7 zero match high", int'(mat_out[0]), 1);

    // R3: counter mode, count input edges
    wreg(0, 2); wreg(8, 0); wreg(0, 5);
    for (int k = 0; k < 10; k++) begin
      cnt_in = 1; idle(2); cnt_in = 0; idle(3);
    end
    idle(4); rdchk("R3 edge count", 3);
    idle(10); rdchk("R3 holds", 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule